// File: doc/BRIEF.md
# Lock acquisition sweep controller

This block steers the coarse tuning offset of an oscillator loop that has to find phase lock and then hold it. An internal prescaler derives a slow step tick from the system clock. While the loop reports no lock, every tick advances an 8-bit code by one. The code feeds an external DAC, so the tuning offset ramps repeatedly across its full range until the oscillator comes within capture range.

Once the lock flag goes high, the ramp stops and the code stays at the value it had when lock was seen. From then on, the fine-correction monitor supplies two threshold flags for each polarity. One flag arms the correction and the other keeps it armed, which gives the correction hysteresis. While a polarity is armed, each tick moves the code one step in the direction that takes load off the fine loop. In this mode the code stops at the ends of its range instead of wrapping. If lock is lost, the ramp resumes from the current code.

All external flags pass through two-flop synchronizers before the block uses them. The comparators, the DAC and the coil drivers lie outside the block.

Top module: `sweep_ctrl`

## Requirements
- R1: The code changes only on tick cycles, and a tick occurs once every TICK_DIV clock cycles. The first tick falls on the TICK_DIV-th rising edge after reset is released.
- R2: While lock is low, each tick adds one to the code.
- R3: While lock is low, a tick at code 255 gives code 0.
- R4: While lock is high and neither correction polarity is armed, the code holds the value it had when lock was seen.
- R5: While lock is high, an armed positive correction adds one to the code on each tick, and an armed negative correction subtracts one.
- R6: A polarity becomes armed when its trip flag is high. It stays armed while its hold flag is high, even after the trip flag falls. It disarms when both flags are low.
- R7: While lock is high, the code saturates at 255 when stepping up and at 0 when stepping down.
- R8: While lock is high and both polarities are armed, the code does not change.
- R9: While lock is low, the correction flags have no effect on the ramp.
- R10: When lock falls, the ramp continues from the current code, not from zero.
- R11: While rst_ni is low, the code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lock_i | input | 1 | Loop-locked flag (asynchronous) |
| pos_trip_i | input | 1 | Positive correction above the arm threshold |
| pos_hold_i | input | 1 | Positive correction above the release threshold |
| neg_trip_i | input | 1 | Negative correction above the arm threshold |
| neg_hold_i | input | 1 | Negative correction above the release threshold |
| code_o | output | 8 | Coarse tuning offset code for the DAC |

## Verification
The unlocked ramp is run past more than one wrap, and the code is checked at every tick and also between ticks. Correction flags are toggled during the ramp to show that they are ignored there. Lock is then applied at an arbitrary point, and the frozen code is checked. The correction flags are then driven in separate patterns: trip with hold, hold only, neither flag, and both polarities together. These patterns separate arming, hysteretic release and cancellation. The code is driven into both end stops to show saturation rather than wrap. Dropping lock last shows that the ramp resumes from the held value instead of restarting.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  typedef enum logic {
    MODE_SWEEP = 1'b0,
    MODE_TRACK = 1'b1
  } sweep_mode_e;

  localparam int unsigned DIR_POS = 0;
  localparam int unsigned DIR_NEG = 1;
  localparam int unsigned N_DIR   = 2;
endpackage

// File: rtl/sweep_sync.sv
module sweep_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sweep_tick.sv
module sweep_tick #(
  parameter int unsigned TICK_DIV = 976_563
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  if (TICK_DIV > 1) begin : g_chk
    assert_tick_spacing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);
  end
endmodule

// File: rtl/sweep_hyst.sv
module sweep_hyst (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trip_i,
  input  logic hold_i,
  output logic armed_o
);
  logic armed_q;

  // trip dominates; release only once the lower threshold is also gone
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      armed_q <= 1'b0;
    else if (trip_i)  armed_q <= 1'b1;
    else if (!hold_i) armed_q <= 1'b0;
  end

  assign armed_o = armed_q;

  assert_arm_on_trip_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_i |=> armed_o);
  assert_keep_while_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && hold_i) |=> armed_o);
  assert_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trip_i && !hold_i) |=> !armed_o);
endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
  import sweep_pkg::*;
#(
  parameter int unsigned CODE_W      = 8,
  parameter int unsigned TICK_DIV    = 976_563,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_i,
  input  logic              pos_trip_i,
  input  logic              pos_hold_i,
  input  logic              neg_trip_i,
  input  logic              neg_hold_i,
  output logic [CODE_W-1:0] code_o
);
  localparam int unsigned N_IN = 1 + 2 * N_DIR;
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  logic [N_IN-1:0]  raw, syn;
  logic [N_DIR-1:0] trip_s, hold_s, armed;
  logic             lock_s, tick;
  sweep_mode_e      mode;
  logic             step_up, step_dn;
  logic [CODE_W-1:0] code_q, code_d;

  assign raw = {neg_hold_i, neg_trip_i, pos_hold_i, pos_trip_i, lock_i};

  sweep_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(raw), .q_o(syn)
  );

  assign lock_s = syn[0];

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    assign trip_s[d] = syn[1 + 2*d];
    assign hold_s[d] = syn[2 + 2*d];
    sweep_hyst u_hyst (
      .clk_i, .rst_ni, .trip_i(trip_s[d]), .hold_i(hold_s[d]), .armed_o(armed[d])
    );
  end

  sweep_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i, .rst_ni, .tick_o(tick)
  );

  assign mode    = lock_s ? MODE_TRACK : MODE_SWEEP;
  assign step_up = armed[DIR_POS] && !armed[DIR_NEG];
  assign step_dn = armed[DIR_NEG] && !armed[DIR_POS];

  always_comb begin
    code_d = code_q;
    if (tick) begin
      unique case (mode)
        MODE_SWEEP: code_d = code_q + 1'b1;
        MODE_TRACK: begin
          if (step_up && code_q != CODE_MAX)  code_d = code_q + 1'b1;
          else if (step_dn && code_q != '0)   code_d = code_q - 1'b1;
        end
        default: code_d = code_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= '0;
    else         code_q <= code_d;
  end

  assign code_o = code_q;

  assert_only_on_tick_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(code_o));
  assert_sweep_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !lock_s && code_o == CODE_MAX) |=> code_o == '0);
  assert_freeze_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_s && armed == '0) |=> $stable(code_o));
  assert_sat_top_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_s && code_o == CODE_MAX) |=> code_o != '0);
  assert_sat_bottom_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_s && code_o == '0) |=> code_o != CODE_MAX);
  assert_cancel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_s && &armed) |=> $stable(code_o));
endmodule

// File: tb/sweep_ctrl_tb.sv
module sweep_ctrl_tb;
  localparam int DIV = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       lock = 1'b0;
  logic       pt = 1'b0, ph = 1'b0, nt = 1'b0, nh = 1'b0;
  logic [7:0] code;
  int         total = 0, bad = 0;
  int         expv = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  sweep_ctrl #(.CODE_W(8), .TICK_DIV(DIV), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .lock_i(lock),
    .pos_trip_i(pt), .pos_hold_i(ph), .neg_trip_i(nt), .neg_hold_i(nh),
    .code_o(code)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Advance one tick period; code must stay put until the tick edge (R1).
  task automatic tick_chk(input string req, input int exp);
    int prev;
    prev = code;
    for (int c = 1; c < DIV; c++) begin
      @(posedge clk); #1;
      if (code != prev) chk("R1", code, prev);
    end
    total++;
    @(posedge clk); #1;
    chk(req, code, exp);
  endtask

  task automatic sweep_tick(input string req);
    expv = (expv + 1) % 256;
    tick_chk((expv == 0) ? "R3" : req, expv);
  endtask

  task automatic track_tick(input string req, input int dir);
    expv = expv + dir;
    if (expv > 255) expv = 255;
    if (expv < 0) expv = 0;
    tick_chk(req, expv);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R11", code, 0);
    @(negedge clk) rst_ni = 1'b1;
    for (int c = 0; c < DIV; c++) @(posedge clk);
    #1 expv = 1;
    chk("R1", code, 1);

    // unlocked ramp through more than one wrap; flags toggled meanwhile (R9)
    for (int t = 0; t < 336; t++) begin
      if (t == 100) begin pt = 1; ph = 1; end
      if (t == 110) begin pt = 0; ph = 0; end
      if (t == 120) begin nt = 1; nh = 1; end
      if (t == 130) begin nt = 0; nh = 0; end
      sweep_tick((t >= 100 && t < 140) ? "R9" : "R2");
    end

    // lock at arbitrary point
    lock = 1;
    for (int t = 0; t < 5; t++) track_tick("R4", 0);

    pt = 1; ph = 1;
    for (int t = 0; t < 3; t++) track_tick("R5", 1);
    pt = 0;
    for (int t = 0; t < 3; t++) track_tick("R6", 1);
    ph = 0;
    for (int t = 0; t < 3; t++) track_tick("R6", 0);

    pt = 1; ph = 1;
    while (expv < 255) track_tick("R5", 1);
    for (int t = 0; t < 4; t++) track_tick("R7", 1);
    pt = 0; ph = 0;

    nt = 1; nh = 1;
    for (int t = 0; t < 3; t++) track_tick("R5", -1);
    nt = 0;
    while (expv > 0) track_tick("R6", -1);
    for (int t = 0; t < 4; t++) track_tick("R7", -1);
    nh = 0;
    for (int t = 0; t < 2; t++) track_tick("R6", 0);

    pt = 1; ph = 1;
    for (int t = 0; t < 10; t++) track_tick("R5", 1);
    nt = 1; nh = 1;
    for (int t = 0; t < 4; t++) track_tick("R8", 0);
    pt = 0; ph = 0; nt = 0; nh = 0;
    for (int t = 0; t < 2; t++) track_tick("R4", 0);

    lock = 0;
    for (int t = 0; t < 5; t++) sweep_tick("R10");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule